// File: doc/BRIEF.md
# Static-Ratio Reference Clock Divider

This block divides a reference clock by an integer ratio to produce the comparison pulse train for a phase/frequency detector. The ratio is a 10-bit value taken from static configuration inputs that are tied off or held constant. It is not captured from any bus, and the load strobe does not latch it. Each output pulse lasts exactly one high phase of the reference clock. The pulse is the reference clock gated by a registered terminal-count flag, so with a ratio of one the reference clock appears unchanged at the output.

A load strobe shared with the rest of the synthesiser holds the divider in reset while it is high. The divider then starts counting on the first rising edge at which the strobe is sampled low, together with the feedback counters. This gives the reference path and the feedback path a common time origin after every reprogramming. A ratio input of zero is not rejected. It divides by 1024, which is the natural wrap of a 10-bit down counter.

Top module: `ref_divider`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, `fref` is low. The divider leaves reset only after two rising edges of `ref_clk` with `rst_n` high.
- R2: On every cycle following a rising edge at which `strobe` is sampled high, `fref` stays low and the count is cleared.
- R3: After `strobe` is sampled low, the first output pulse occupies the high phase that follows the R-th such rising edge, where R is the effective ratio.
- R4: While `strobe` stays low, successive pulses are exactly R reference cycles apart, so the output frequency is the reference frequency divided by R.
- R5: `fref` is high only during the high phase of `ref_clk`, and in a pulse cycle it is high for the whole of that phase. It is always low during the low phase.
- R6: With `ratio` = 1 and `strobe` low, `fref` equals `ref_clk` in every cycle.
- R7: `ratio` = 0 divides by 1024.
- R8: `ratio` = 1023 divides by 1023.
- R9: Raising `strobe` in the middle of a count discards the partial count. Counting restarts from the first low-sampled edge, as in R3.
- R10: A change of `ratio` while counting takes effect at the next pulse. The period in progress finishes with the old ratio, and the period that starts with that pulse uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, also the source of the output pulse shape |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe | input | 1 | Load strobe, synchronous to `ref_clk`; high holds the divider in reset |
| ratio | input | 10 | Static division ratio; 0 means 1024 |
| fref | output | 1 | Divided comparison pulse, one reference high phase wide |

## Verification
The bench builds the block with its default 10-bit ratio width. This default makes the full range reachable, from pass-through at ratio 1 to the wrap case at ratio 0 (1024) and the largest coded ratio of 1023, each of which runs for two full periods. Small ratios exercise first-pulse alignment after the strobe, back-to-back terminal counts and a strobe raised mid-count. A ratio change without the strobe shows which period picks up the new value. The output is sampled inside both clock phases, so the width and the placement of each pulse are checked as well as its period.

// File: rtl/refdiv_pkg.sv
`timescale 1ns/1ps
package refdiv_pkg;
  localparam int unsigned RDIV_W_DEF   = 10;
  localparam int unsigned RDIV_SYNC_DEF = 2;
endpackage

// File: rtl/refdiv_rst_sync.sv
`timescale 1ns/1ps
module refdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/refdiv_counter.sv
`timescale 1ns/1ps
module refdiv_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] ratio,
  output logic         terminal
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         at_zero;
  logic         cnt_en;

  assign at_zero = (cnt_q == '0);
  assign cnt_en  = !hold;

  // Down counter: zero marks the terminal cycle; reload with ratio-1,
  // whose 10-bit wrap turns a zero ratio into a 1024 period.
  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (!cnt_en) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (at_zero) begin
      cnt_d = ratio - 1'b1;
      run_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign terminal = run_q && at_zero;
endmodule

// File: rtl/refdiv_shaper.sv
`timescale 1ns/1ps
module refdiv_shaper (
  input  logic clk,
  input  logic terminal,
  output logic pulse
);
  // Terminal flag changes only at rising edges; AND with the clock yields
  // exactly the high phase of the terminal cycle.
  assign pulse = clk & terminal;
endmodule

// File: rtl/ref_divider.sv
`timescale 1ns/1ps
module ref_divider #(
  parameter int unsigned RATIO_W = refdiv_pkg::RDIV_W_DEF,
  parameter int unsigned SYNC_N  = refdiv_pkg::RDIV_SYNC_DEF
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic [RATIO_W-1:0] ratio,
  output logic               fref
);
  logic srst_n;
  logic term;

  refdiv_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  refdiv_counter #(.W(RATIO_W)) u_cnt (
    .clk      (ref_clk),
    .rst_n    (srst_n),
    .hold     (strobe),
    .ratio    (ratio),
    .terminal (term)
  );

  refdiv_shaper u_shp (
    .clk      (ref_clk),
    .terminal (term),
    .pulse    (fref)
  );
endmodule

// File: rtl/ref_divider_chk.sv
`timescale 1ns/1ps
module ref_divider_chk #(
  parameter int unsigned RATIO_W = 10
) (
  input logic               ref_clk,
  input logic               rst_n,
  input logic               strobe,
  input logic [RATIO_W-1:0] ratio,
  input logic               term,
  input logic               fref
);
  // R2: a sampled strobe leaves no terminal cycle behind it
  a_r2_strobe_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
    strobe |=> !term);

  // R5: sampled just before a rising edge (clock low) the output is low
  a_r5_low_phase: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !fref);

  // R4: ratios above one never give back-to-back terminal cycles
  a_r4_no_adjacent: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (term && !strobe && ratio != 1) |=> !term);

  // R6: at unity ratio every cycle is a terminal cycle
  a_r6_unity: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (term && !strobe && ratio == 1) |=> term);
endmodule

bind ref_divider ref_divider_chk #(.RATIO_W(RATIO_W)) u_chk (
  .ref_clk (ref_clk),
  .rst_n   (rst_n),
  .strobe  (strobe),
  .ratio   (ratio),
  .term    (term),
  .fref    (fref)
);

// File: tb/ref_divider_test.sv
`timescale 1ns/1ps
module ref_divider_test;
  localparam real HALF = 2.5;
  localparam int  WD_CYCLES = 150000;

  logic       ref_clk;
  logic       rst_n;
  logic       strobe;
  logic [9:0] ratio;
  logic       fref;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  string cur_req = "R1";
  bit    done = 0;

  ref_divider uut (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .ratio   (ratio),
    .fref    (fref)
  );

  initial ref_clk = 1'b0;
  always #(HALF) ref_clk = ~ref_clk;

  // Behavioural model: edges counted since the period began vs. its length
  bit exp_pulse = 0;
  bit m_act = 0;
  int m_since = 0;
  int m_target = 0;

  always @(posedge ref_clk) begin
    if (!rst_n || strobe) begin
      m_act = 0;
      exp_pulse = 0;
    end else if (!m_act || exp_pulse) begin
      m_target = (ratio == 0) ? 1024 : int'(ratio);
      m_since = 1;
      m_act = 1;
      exp_pulse = (m_since == m_target);
    end else begin
      m_since = m_since + 1;
      exp_pulse = (m_since == m_target);
    end
  end

  task automatic check(input logic got, input logic want, input string req);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s at %0t: fref=%b expected %b", req, $time, got, want);
    end
  endtask

  // High phase: pulse as modelled (R3/R4/R6..R10 per phase, R5 width)
  always @(posedge ref_clk) begin
    #1.25;
    if (!done) check(fref, exp_pulse, cur_req);
  end
  // Low phase: always low (R5)
  always @(negedge ref_clk) begin
    #1.25;
    if (!done) check(fref, 1'b0, "R5");
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic run_ratio(input logic [9:0] r, input int n, input string req);
    cur_req = "R2";
    strobe = 1'b1;
    ratio = r;
    cycles(3);
    cur_req = req;
    strobe = 1'b0;
    cycles(n);
  endtask

  initial begin
    rst_n = 1'b0;
    strobe = 1'b1;
    ratio = 10'd5;
    cur_req = "R1";
    cycles(4);
    rst_n = 1'b1;
    cur_req = "R2";
    cycles(4);

    run_ratio(10'd1, 30, "R6");
    run_ratio(10'd2, 20, "R3");
    run_ratio(10'd3, 25, "R4");
    run_ratio(10'd7, 40, "R4");
    run_ratio(10'd13, 60, "R3");
    run_ratio(10'd1023, 2100, "R8");
    run_ratio(10'd0, 2100, "R7");

    // R9: strobe raised mid-count
    run_ratio(10'd6, 10, "R9");
    cur_req = "R2";
    strobe = 1'b1;
    cycles(3);
    cur_req = "R9";
    strobe = 1'b0;
    cycles(20);

    // R10: ratio changed without strobe
    run_ratio(10'd4, 9, "R10");
    ratio = 10'd9;
    cycles(40);
    ratio = 10'd1;
    cycles(20);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge ref_clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule